// File: doc/BRIEF.md
# ADC Channel-Group Result Register Bank

This block keeps the latest conversion result of every channel group of an analog-to-digital converter and lets a bus master read it as one 16-bit word. The converter side supplies a raw value of up to 12 bits, a write strobe and a group number. The block formats the value as it is stored. Two configuration inputs control the format. One picks 12-bit or 10-bit resolution; the 10-bit result is the upper ten bits of the raw value. The other picks right or left alignment inside the 16-bit word. Bits outside the result field read as zero.

Each group's register can be read at two addresses, one in each of two aliased windows. Within a window, group i sits at the window base plus 4*i. A mode input chooses between two read behaviours. With the mode clear, a result stays in place until the next conversion for that group replaces it. With the mode set, the register becomes zero once it has been read through either alias. Read data appears on the cycle after the read strobe.

Top module: `adc_result_regs`

## Requirements
- R1: After a synchronous active-low reset, every group reads 0x0000 through both aliases.
- R2: With resolution select 0 and alignment select 0, a stored 12-bit raw value occupies bits [11:0] and bits [15:12] are zero.
- R3: With resolution select 0 and alignment select 1, the 12-bit raw value occupies bits [15:4] and bits [3:0] are zero.
- R4: With resolution select 1 and alignment select 0, raw bits [11:2] occupy bits [9:0] and bits [15:10] are zero.
- R5: With resolution select 1 and alignment select 1, raw bits [11:2] occupy bits [15:6] and bits [5:0] are zero.
- R6: With the clear-on-read mode input at 0, reads do not change a stored result. It changes only when a conversion for the same group writes a new value.
- R7: With the clear-on-read mode input at 1, a read through either alias returns the stored value, and the register holds 0x0000 from the next cycle on.
- R8: Group i is read at address BASE_A+4*i and at address BASE_B+4*i. A conversion write to one group leaves every other group unchanged.
- R9: If a conversion write and a clearing read hit the same group in the same cycle, the register takes the new formatted value and is not cleared.
- R10: The read data register loads on the clock edge that samples the read strobe. It holds while the strobe is low. A read of an address that maps to no group returns 0x0000 and clears nothing.
- R11: The format is applied when a result is stored. Changing the resolution or alignment select later does not change a stored result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_res10 | input | 1 | Resolution select: 0 = 12-bit, 1 = 10-bit |
| cfg_left | input | 1 | Alignment select: 0 = right, 1 = left |
| cfg_clr_on_read | input | 1 | 1 = clear a result after it is read |
| conv_valid | input | 1 | Conversion result write strobe |
| conv_group | input | GRP_W (2) | Channel group of the conversion result |
| conv_data | input | RAW_W (12) | Raw conversion value |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W (8) | Bus byte address |
| rd_data | output | DATA_W (16) | Read data, valid the cycle after rd_en |

## Verification
The assertions check on every cycle that each formatted word has zeros in the bits outside its result field. They also check that at most one group decodes per read, and that a clearing read empties its register unless a same-cycle write takes priority. Further cycle checks cover that a register with no write and no clearing read keeps its value, and that the read data register holds or returns zero as R10 describes. Only the bench scenarios can show the actual bit placement of the values across all four formats. The same holds for the alias address mapping, the read latency against expected values, isolation between groups, and formats staying fixed after a configuration change.

// File: rtl/adc_res_pkg.sv
// Package adc_res_pkg
// Shared widths and the format encoding for the ADC result register bank.
// Assumes the packed format code is {resolution select, alignment select}.
package adc_res_pkg;

    localparam int RES_DATA_W = 16;
    localparam int RES_RAW_W  = 12;
    localparam int RES_LOW_W  = 10;

    // Format code: bit 1 = reduced resolution, bit 0 = left alignment
    typedef enum logic [1:0] {
        FMT_FULL_RIGHT = 2'b00,
        FMT_FULL_LEFT  = 2'b01,
        FMT_LOW_RIGHT  = 2'b10,
        FMT_LOW_LEFT   = 2'b11
    } res_fmt_e;

endpackage

// File: rtl/adc_res_fmt.sv
// Module adc_res_fmt
// Places a raw conversion value in a DATA_W-bit word by resolution and
// alignment. The reduced-resolution result is the upper LOW_W bits of the
// raw value. Assumes DATA_W > RAW_W > LOW_W. Purely combinational.
module adc_res_fmt
    import adc_res_pkg::*;
#(
    parameter int DATA_W = RES_DATA_W,
    parameter int RAW_W  = RES_RAW_W,
    parameter int LOW_W  = RES_LOW_W
) (
    input  logic              res_low,
    input  logic              align_left,
    input  logic [RAW_W-1:0]  raw,
    output logic [DATA_W-1:0] word
);

    localparam int PAD_FULL = DATA_W - RAW_W;
    localparam int PAD_LOW  = DATA_W - LOW_W;

    res_fmt_e            fmt;
    logic [LOW_W-1:0]    reduced;

    assign fmt     = res_fmt_e'({res_low, align_left});
    assign reduced = raw[RAW_W-1 -: LOW_W];

    // Select the field position for the requested format
    always_comb begin
        unique case (fmt)
            FMT_FULL_RIGHT: word = {{PAD_FULL{1'b0}}, raw};
            FMT_FULL_LEFT:  word = {raw, {PAD_FULL{1'b0}}};
            FMT_LOW_RIGHT:  word = {{PAD_LOW{1'b0}}, reduced};
            default:        word = {reduced, {PAD_LOW{1'b0}}};
        endcase
    end

endmodule

// File: rtl/adc_res_decode.sv
// Module adc_res_decode
// Maps a bus byte address to a one-hot group hit. Group i answers at
// BASE_A+4*i and at BASE_B+4*i. Assumes the two windows do not overlap.
module adc_res_decode #(
    parameter int                NUM_GROUPS = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_A     = 8'h00,
    parameter logic [ADDR_W-1:0] BASE_B     = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [NUM_GROUPS-1:0] hit
);

    localparam int STRIDE = 4;

    // One comparator pair per group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] ADDR_A = BASE_A + ADDR_W'(STRIDE * g);
        localparam logic [ADDR_W-1:0] ADDR_B = BASE_B + ADDR_W'(STRIDE * g);
        assign hit[g] = rd_en && ((rd_addr == ADDR_A) || (rd_addr == ADDR_B));
    end

    // At most one group may answer a given read address (R8)
    assert_one_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // No group answers without a read strobe (R10)
    assert_no_idle_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (hit == '0));

endmodule

// File: rtl/adc_res_slot.sv
// Module adc_res_slot
// One stored result for one channel group. A write loads the formatted
// word. A clearing read zeroes it one edge later. A write in the same
// cycle takes priority over the clear.
module adc_res_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rd_clear,
    output logic [DATA_W-1:0] value
);

    // Store, clear or hold the result
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_en)
            value <= wr_word;
        else if (rd_clear)
            value <= '0;
    end

    // A clearing read with no write leaves zero (R7)
    assert_clear_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !wr_enen_guard()) |=> (value == '0));

    function automatic logic wr_enen_guard();
        return wr_en;
    endfunction

    // A write wins over a simultaneous clear (R9)
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_clear) |=> (value == $past(wr_word)));

    // Without a write or a clearing read, the result is kept (R6)
    assert_keep_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_clear) |=> $stable(value));

endmodule

// File: rtl/adc_result_regs.sv
// Module adc_result_regs
// Result register bank for NUM_GROUPS ADC channel groups. Conversion
// values are formatted as they are stored. A bus read returns the stored
// word one cycle after the strobe and, in clear-on-read mode, zeroes it.
// Assumes conv_group values of NUM_GROUPS or above are ignored.
module adc_result_regs
    import adc_res_pkg::*;
#(
    parameter int                NUM_GROUPS = 4,
    parameter int                DATA_W     = RES_DATA_W,
    parameter int                RAW_W      = RES_RAW_W,
    parameter int                LOW_W      = RES_LOW_W,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_A     = 8'h00,
    parameter logic [ADDR_W-1:0] BASE_B     = 8'h40,
    localparam int               GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_res10,
    input  logic              cfg_left,
    input  logic              cfg_clr_on_read,
    input  logic              conv_valid,
    input  logic [GRP_W-1:0]  conv_group,
    input  logic [RAW_W-1:0]  conv_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0]     fmt_word;
    logic [NUM_GROUPS-1:0] grp_hit;
    logic [NUM_GROUPS-1:0] grp_wr;
    logic [DATA_W-1:0]     grp_val [NUM_GROUPS];
    logic [DATA_W-1:0]     sel_or  [NUM_GROUPS+1];

    adc_res_fmt #(
        .DATA_W (DATA_W),
        .RAW_W  (RAW_W),
        .LOW_W  (LOW_W)
    ) u_fmt (
        .res_low    (cfg_res10),
        .align_left (cfg_left),
        .raw        (conv_data),
        .word       (fmt_word)
    );

    adc_res_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .BASE_A     (BASE_A),
        .BASE_B     (BASE_B)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .hit     (grp_hit)
    );

    assign sel_or[0] = '0;

    // Per-group slot, write select and read-mux stage
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
        assign grp_wr[g] = conv_valid && (conv_group == GRP_W'(g));

        adc_res_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (grp_wr[g]),
            .wr_word  (fmt_word),
            .rd_clear (grp_hit[g] && cfg_clr_on_read),
            .value    (grp_val[g])
        );

        assign sel_or[g+1] = sel_or[g] | (grp_hit[g] ? grp_val[g] : '0);
    end

    // Register the selected word on every read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel_or[NUM_GROUPS];
    end

    // Formatted word leaves the bits outside its field at zero (R2..R5)
    assert_fmt_full_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !cfg_res10 && !cfg_left) |-> (fmt_word[DATA_W-1:RAW_W] == '0));
    assert_fmt_full_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !cfg_res10 && cfg_left) |-> (fmt_word[DATA_W-RAW_W-1:0] == '0));
    assert_fmt_low_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && cfg_res10 && !cfg_left) |-> (fmt_word[DATA_W-1:LOW_W] == '0));
    assert_fmt_low_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && cfg_res10 && cfg_left) |-> (fmt_word[DATA_W-LOW_W-1:0] == '0));

    // Unmapped read returns zero; idle cycles hold the read data (R10)
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (grp_hit == '0)) |=> (rd_data == '0));
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/adc_result_regs_test.sv
// Bench for adc_result_regs: a vector table walked by one loop, then
// directed reset and corner-case tests.
module adc_result_regs_test;

    localparam int NG = 4;
    localparam logic [7:0] BA = 8'h00;
    localparam logic [7:0] BB = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_res10 = 1'b0;
    logic        cfg_left = 1'b0;
    logic        cfg_clr_on_read = 1'b0;
    logic        conv_valid = 1'b0;
    logic [1:0]  conv_group = '0;
    logic [11:0] conv_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_result_regs uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_res10       (cfg_res10),
        .cfg_left        (cfg_left),
        .cfg_clr_on_read (cfg_clr_on_read),
        .conv_valid      (conv_valid),
        .conv_group      (conv_group),
        .conv_data       (conv_data),
        .rd_en           (rd_en),
        .rd_addr         (rd_addr),
        .rd_data         (rd_data)
    );

    // Vector: {res10, left, raw[11:0], expected[15:0]}
    localparam int NV = 9;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 1'b0, 12'hABC, 16'h0ABC},   // R2
        {1'b0, 1'b1, 12'hABC, 16'hABC0},   // R3
        {1'b1, 1'b0, 12'hABC, 16'h02AF},   // R4
        {1'b1, 1'b1, 12'hABC, 16'hABC0},   // R5
        {1'b0, 1'b0, 12'hFFF, 16'h0FFF},   // R2
        {1'b1, 1'b0, 12'hFFF, 16'h03FF},   // R4
        {1'b1, 1'b1, 12'h001, 16'h0000},   // R5
        {1'b0, 1'b1, 12'h801, 16'h8010},   // R3
        {1'b1, 1'b0, 12'h007, 16'h0001}    // R4
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic conv_write(input logic [1:0] g, input logic [11:0] raw);
        @(negedge clk);
        conv_valid = 1'b1; conv_group = g; conv_data = raw;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] addr_a(input int g);
        return BA + 8'(4 * g);
    endfunction

    function automatic logic [7:0] addr_b(input int g);
        return BB + 8'(4 * g);
    endfunction

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all groups zero through both aliases after reset
        for (int g = 0; g < NG; g++) begin
            bus_read(addr_a(g), d); check("R1 reset alias A", d, 16'h0000);
            bus_read(addr_b(g), d); check("R1 reset alias B", d, 16'h0000);
        end

        // R2..R5: vector loop, keep mode, alternating alias
        for (int k = 0; k < NV; k++) begin
            cfg_res10 = VEC[k][29];
            cfg_left  = VEC[k][28];
            conv_write(2'(k % NG), VEC[k][27:16]);
            bus_read(((k % 2) == 0) ? addr_a(k % NG) : addr_b(k % NG), d);
            check("R2-5 format vector", d, VEC[k][15:0]);
        end

        // R6: keep mode, repeated reads do not alter the value
        cfg_res10 = 1'b0; cfg_left = 1'b0; cfg_clr_on_read = 1'b0;
        conv_write(2'd1, 12'h5A5);
        bus_read(addr_a(1), d); check("R6 first read", d, 16'h05A5);
        bus_read(addr_b(1), d); check("R6 second read", d, 16'h05A5);

        // R8: writes to one group leave others unchanged
        conv_write(2'd0, 12'h111);
        conv_write(2'd2, 12'h222);
        conv_write(2'd3, 12'h333);
        bus_read(addr_b(1), d); check("R8 group 1 isolated", d, 16'h05A5);
        bus_read(addr_a(2), d); check("R8 group 2 alias A", d, 16'h0222);
        bus_read(addr_b(3), d); check("R8 group 3 alias B", d, 16'h0333);

        // R11: changing format after storing does not change the value
        cfg_res10 = 1'b1; cfg_left = 1'b1;
        bus_read(addr_a(0), d); check("R11 format fixed at store", d, 16'h0111);

        // R7: clear-on-read through alias B, then alias A sees zero
        cfg_res10 = 1'b0; cfg_left = 1'b0; cfg_clr_on_read = 1'b1;
        conv_write(2'd2, 12'h123);
        bus_read(addr_b(2), d); check("R7 read returns value", d, 16'h0123);
        bus_read(addr_a(2), d); check("R7 cleared after read", d, 16'h0000);
        conv_write(2'd1, 12'h0F0);
        bus_read(addr_a(1), d); check("R7 alias A read", d, 16'h00F0);
        bus_read(addr_b(1), d); check("R7 alias A clears", d, 16'h0000);

        // R9: same-cycle write and clearing read on group 3
        @(negedge clk);
        conv_valid = 1'b1; conv_group = 2'd3; conv_data = 12'h456;
        rd_en = 1'b1; rd_addr = addr_a(3);
        @(posedge clk);
        #1 check("R9 read returns old value", rd_data, 16'h0333);
        @(negedge clk);
        conv_valid = 1'b0; rd_en = 1'b0;
        cfg_clr_on_read = 1'b0;
        bus_read(addr_b(3), d); check("R9 write wins over clear", d, 16'h0456);

        // R10: unmapped addresses return zero and clear nothing
        cfg_clr_on_read = 1'b1;
        bus_read(8'h02, d); check("R10 misaligned unmapped", d, 16'h0000);
        bus_read(8'h20, d); check("R10 gap unmapped", d, 16'h0000);
        cfg_clr_on_read = 1'b0;
        bus_read(addr_a(0), d); check("R10 unmapped cleared nothing", d, 16'h0111);

        // R10: one-cycle latency and hold while strobe is low
        @(negedge clk);
        rd_en = 1'b1; rd_addr = addr_a(3);
        check("R10 data not yet updated", rd_data, 16'h0111);
        @(posedge clk);
        #1 check("R10 data after one edge", rd_data, 16'h0456);
        @(negedge clk);
        rd_en = 1'b0; rd_addr = addr_a(0);
        repeat (2) @(negedge clk);
        check("R10 hold without strobe", rd_data, 16'h0456);

        // R1: mid-run reset clears stored results
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 read data after reset", rd_data, 16'h0000);
        bus_read(addr_b(3), d); check("R1 group cleared by reset", d, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule